// File: doc/BRIEF.md
# Sensorless Motor Start-Up Sequencer

This controller takes a three-phase sensorless motor drive from power-on to closed-loop running. It passes through a fixed chain of stages: a calibration interval, a rotor alignment interval, a resistance-measurement interval, an open-loop ramp, a Kt-measurement interval, and then closed loop. During alignment phase U is tied low while V and W are driven. During the ramp the commutation rate climbs linearly. When it reaches a configured handoff frequency, the sequencer passes control to the closed-loop side. The measurement intervals appear only as fixed-length stages. Waveform synthesis and speed estimation sit outside this block.

Two 4-bit codes set the start profile. The first code sets both the alignment time and the ramp slope. The second code sets the handoff frequency. A 3-bit supply band selects the drive duty used from alignment through the Kt interval, so starting torque stays roughly constant across supply levels. A lock or fault flag puts the phase outputs in high impedance for a fixed recovery wait, after which the full start-up chain runs again.

Time is counted in milliseconds. `TICKS_PER_MS` clock cycles make one millisecond. The commutation rate is carried in milli-hertz. A phase accumulator advances the six-step commutation index in the direction given by a direction input.

Top module: `motor_start_seq`

## Requirements
- R1: While reset is low, and for two clock edges after `rst_ni` rises, the outputs are as follows: stage = 0 (calibration), `tristate_o` = 1, `drive_duty_o` = 0, `comm_rate_o` = 0 and `comm_step_o` = 0.
- R2: Stage codes are 0 calibration, 1 align, 2 resistance measurement, 3 ramp, 4 Kt measurement, 5 closed loop and 6 recovery wait. The stages run in the order 0,1,2,3,4,5. Calibration lasts `CAL_MS`, resistance measurement lasts `RMEAS_MS` and Kt measurement lasts `KTM_MS`. Each of these is measured in ms of `TICKS_PER_MS` cycles.
- R3: Alignment lasts 40·A ms, where A is the alignment/ramp code. A code of 0 is treated as 1. `comm_step_o` reads 0 during alignment (U low, V and W driven).
- R4: In stages 1 to 4, `drive_duty_o` (in percent) depends on the supply band. Band 0 (5.25–6 V) gives 43. Band 1 (4.5–5.25 V) gives 50. Band 2 (3.75–4.5 V) gives 60. Band 3 (3–3.75 V) gives 75. Bands 4 to 7 (below 3 V) give 100.
- R5: The ramp starts at 0 mHz. At the end of every ms it adds (160 − 10·A) mHz, with the sum clamped to the handoff threshold. The stage moves to Kt measurement one cycle after the threshold is reached. The ramp stage therefore lasts ceil(T/rate)·`TICKS_PER_MS` + 1 cycles.
- R6: The handoff threshold T is 12500·H mHz (12.5·H Hz), where H is the handoff code. A code of 0 is treated as 1. `comm_rate_o` holds T through Kt measurement and closed loop.
- R7: From the ramp onward, `comm_step_o` takes six steps per electrical cycle at the rate on `comm_rate_o`. Over 0.4 s at T = 12500·H mHz that is exactly 30·H steps.
- R8: With `dir_i` = 1 each step goes up by 1 modulo 6 (U→V→W). With `dir_i` = 0 each step goes down by 1 modulo 6 (U→W→V). A change of `dir_i` while running takes effect from the next step.
- R9: A high `lock_i` or `fault_i` in any stage other than the recovery wait sends the block to stage 6 on the next cycle. The recovery wait lasts `LOCK_WAIT_MS` (5000 ms) regardless of further flags. The block then re-enters calibration with the rate and step cleared.
- R10: `tristate_o` is 1 exactly in calibration and the recovery wait. `drive_duty_o` is 0 in stages 0, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ta_code_i | input | 4 | Alignment time / ramp slope code |
| ho_code_i | input | 4 | Handoff frequency code |
| vband_i | input | 3 | Supply voltage band |
| dir_i | input | 1 | Rotation direction |
| lock_i | input | 1 | Rotor lock detected |
| fault_i | input | 1 | Other protection fault |
| stage_o | output | 3 | Current stage code |
| comm_rate_o | output | FREQ_W | Commutation rate in mHz |
| drive_duty_o | output | 7 | Align/open-loop drive duty in percent |
| comm_step_o | output | 3 | Six-step commutation index |
| tristate_o | output | 1 | Request to float all phases |

## Verification
The start sequence is run with several combinations of the two codes and the supply band. One combination uses zero codes, which must behave exactly like code 1. Another combination gives a handoff threshold that the ramp slope divides exactly, which separates an off-by-one in the ramp exit from the clamped case. Each run measures every stage length and reads the duty, the handoff rate and the step count with its direction, so a mistake in the slope, the threshold or the phase accumulator shows up as a wrong cycle count. Directed cases inject a lock while running, a fault during alignment, a flag during the recovery wait, and a direction flip in closed loop.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;
  typedef enum logic [2:0] {
    ST_CAL    = 3'd0,
    ST_ALIGN  = 3'd1,
    ST_RMEAS  = 3'd2,
    ST_ACCEL  = 3'd3,
    ST_KTM    = 3'd4,
    ST_CLOSED = 3'd5,
    ST_WAIT   = 3'd6
  } seq_stage_e;
endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
  parameter int TICKS_PER_MS = 4,
  parameter int MS_W         = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  output logic            ms_tick_o,
  output logic [MS_W-1:0] ms_cnt_o
);
  localparam int PRE_W = $clog2(TICKS_PER_MS + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;

  assign ms_tick_o = (pre_q == PRE_W'(TICKS_PER_MS - 1));
  assign ms_cnt_o  = ms_q;

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clear_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (ms_tick_o) begin
      pre_d = '0;
      ms_d  = ms_q + MS_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  // R2
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q < PRE_W'(TICKS_PER_MS));
endmodule

// File: rtl/seq_cfg_decode.sv
module seq_cfg_decode #(
  parameter int MS_W          = 13,
  parameter int RATE_W        = 8,
  parameter int FREQ_W        = 18,
  parameter int ALIGN_STEP_MS = 40,
  parameter int RATE_BASE     = 160,
  parameter int RATE_STEP     = 10,
  parameter int HO_STEP_MHZ   = 12500
) (
  input  logic [3:0]        ta_code_i,
  input  logic [3:0]        ho_code_i,
  input  logic [2:0]        vband_i,
  output logic [MS_W-1:0]   align_ms_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [FREQ_W-1:0] thr_o,
  output logic [6:0]        duty_o
);
  logic [3:0] ta_eff, ho_eff;

  assign ta_eff = (ta_code_i == 4'd0) ? 4'd1 : ta_code_i;
  assign ho_eff = (ho_code_i == 4'd0) ? 4'd1 : ho_code_i;

  assign align_ms_o = MS_W'(ta_eff) * MS_W'(ALIGN_STEP_MS);
  assign rate_o     = RATE_W'(RATE_BASE) - RATE_W'(RATE_STEP) * RATE_W'(ta_eff);
  assign thr_o      = FREQ_W'(ho_eff) * FREQ_W'(HO_STEP_MHZ);

  always_comb begin
    case (vband_i)
      3'd0:    duty_o = 7'd43;
      3'd1:    duty_o = 7'd50;
      3'd2:    duty_o = 7'd60;
      3'd3:    duty_o = 7'd75;
      default: duty_o = 7'd100;
    endcase
  end
endmodule

// File: rtl/seq_comm_stepper.sv
module seq_comm_stepper #(
  parameter int FREQ_W  = 18,
  parameter int RATE_W  = 8,
  parameter int PH_WRAP = 4000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ramp_tick_i,
  input  logic              run_i,
  input  logic              dir_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [FREQ_W-1:0] thr_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [2:0]        step_o,
  output logic              at_thr_o
);
  localparam int ACC_W = $clog2(PH_WRAP);
  localparam int SUM_W = ACC_W + 1;

  logic [FREQ_W-1:0] freq_q, freq_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [2:0]        step_q, step_d;
  logic [FREQ_W:0]   fsum;
  logic [SUM_W-1:0]  asum;

  assign fsum = {1'b0, freq_q} + (FREQ_W+1)'(rate_i);
  assign asum = {1'b0, acc_q} + SUM_W'(freq_q) * SUM_W'(6);

  always_comb begin
    freq_d = freq_q;
    acc_d  = acc_q;
    step_d = step_q;
    if (clear_i) begin
      freq_d = '0;
      acc_d  = '0;
      step_d = 3'd0;
    end else begin
      if (ramp_tick_i)
        freq_d = (fsum >= {1'b0, thr_i}) ? thr_i : fsum[FREQ_W-1:0];
      if (run_i) begin
        if (asum >= SUM_W'(PH_WRAP)) begin
          acc_d = ACC_W'(asum - SUM_W'(PH_WRAP));
          if (dir_i) step_d = (step_q == 3'd5) ? 3'd0 : step_q + 3'd1;
          else       step_d = (step_q == 3'd0) ? 3'd5 : step_q - 3'd1;
        end else begin
          acc_d = asum[ACC_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      acc_q  <= '0;
      step_q <= 3'd0;
    end else begin
      freq_q <= freq_d;
      acc_q  <= acc_d;
      step_q <= step_d;
    end
  end

  assign freq_o   = freq_q;
  assign step_o   = step_q;
  assign at_thr_o = (freq_q >= thr_i);

  // R6
  freq_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_tick_i && !clear_i |=> freq_q <= $past(thr_i));
  // R7
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= 3'd5);
  // R8
  step_adj_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != $past(step_q)) && !$past(clear_i) |->
      (step_q == $past(step_q) + 3'd1) || (step_q + 3'd1 == $past(step_q)) ||
      ($past(step_q) == 3'd5 && step_q == 3'd0) ||
      ($past(step_q) == 3'd0 && step_q == 3'd5));
endmodule

// File: rtl/motor_start_seq.sv
module motor_start_seq
  import motor_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int CAL_MS       = 300,
  parameter int RMEAS_MS     = 10,
  parameter int KTM_MS       = 10,
  parameter int LOCK_WAIT_MS = 5000,
  parameter int FREQ_W       = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        ta_code_i,
  input  logic [3:0]        ho_code_i,
  input  logic [2:0]        vband_i,
  input  logic              dir_i,
  input  logic              lock_i,
  input  logic              fault_i,
  output logic [2:0]        stage_o,
  output logic [FREQ_W-1:0] comm_rate_o,
  output logic [6:0]        drive_duty_o,
  output logic [2:0]        comm_step_o,
  output logic              tristate_o
);
  localparam int MAX_MS  = (LOCK_WAIT_MS > 600) ? LOCK_WAIT_MS : 600;
  localparam int MS_W    = $clog2(MAX_MS + 1);
  localparam int RATE_W  = 8;
  localparam int PH_WRAP = 1000000 * TICKS_PER_MS;

  logic              rst_meta, rst_n_s;
  seq_stage_e        stage_q, stage_d;
  logic              stage_chg, ms_tick, at_thr, trip;
  logic [MS_W-1:0]   ms_cnt, align_ms;
  logic [RATE_W-1:0] rate;
  logic [FREQ_W-1:0] thr, freq;
  logic [6:0]        duty_sel;
  logic              step_clear, step_run, ramp_tick;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  seq_cfg_decode #(.MS_W(MS_W), .RATE_W(RATE_W), .FREQ_W(FREQ_W)) cfg_i (
    .ta_code_i(ta_code_i), .ho_code_i(ho_code_i), .vband_i(vband_i),
    .align_ms_o(align_ms), .rate_o(rate), .thr_o(thr), .duty_o(duty_sel));

  seq_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) tmr_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .clear_i(stage_chg),
    .ms_tick_o(ms_tick), .ms_cnt_o(ms_cnt));

  assign step_clear = (stage_q == ST_CAL) || (stage_q == ST_ALIGN) ||
                      (stage_q == ST_RMEAS) || (stage_q == ST_WAIT);
  assign step_run   = (stage_q == ST_ACCEL) || (stage_q == ST_KTM) ||
                      (stage_q == ST_CLOSED);
  assign ramp_tick  = ms_tick && (stage_q == ST_ACCEL);

  seq_comm_stepper #(.FREQ_W(FREQ_W), .RATE_W(RATE_W), .PH_WRAP(PH_WRAP)) stp_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .clear_i(step_clear),
    .ramp_tick_i(ramp_tick), .run_i(step_run), .dir_i(dir_i),
    .rate_i(rate), .thr_i(thr), .freq_o(freq), .step_o(comm_step_o),
    .at_thr_o(at_thr));

  assign trip = lock_i || fault_i;

  always_comb begin
    stage_d = stage_q;
    case (stage_q)
      ST_CAL:    if (ms_tick && ms_cnt == MS_W'(CAL_MS - 1))       stage_d = ST_ALIGN;
      ST_ALIGN:  if (ms_tick && ms_cnt == align_ms - MS_W'(1))     stage_d = ST_RMEAS;
      ST_RMEAS:  if (ms_tick && ms_cnt == MS_W'(RMEAS_MS - 1))     stage_d = ST_ACCEL;
      ST_ACCEL:  if (at_thr)                                       stage_d = ST_KTM;
      ST_KTM:    if (ms_tick && ms_cnt == MS_W'(KTM_MS - 1))       stage_d = ST_CLOSED;
      ST_CLOSED: stage_d = ST_CLOSED;
      ST_WAIT:   if (ms_tick && ms_cnt == MS_W'(LOCK_WAIT_MS - 1)) stage_d = ST_CAL;
      default:   stage_d = ST_CAL;
    endcase
    if (trip && stage_q != ST_WAIT) stage_d = ST_WAIT;
  end

  assign stage_chg = (stage_d != stage_q);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) stage_q <= ST_CAL;
    else          stage_q <= stage_d;
  end

  assign stage_o      = stage_q;
  assign comm_rate_o  = freq;
  assign tristate_o   = (stage_q == ST_CAL) || (stage_q == ST_WAIT);
  assign drive_duty_o = (stage_q == ST_ALIGN || stage_q == ST_RMEAS ||
                         stage_q == ST_ACCEL || stage_q == ST_KTM) ? duty_sel : 7'd0;

  // R9
  trip_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    trip && stage_q != ST_WAIT |=> stage_q == ST_WAIT);
  // R10
  float_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    tristate_o |-> drive_duty_o == 7'd0);
  // R2
  ramp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $past(stage_q) == ST_ACCEL && stage_q != ST_ACCEL |->
      stage_q == ST_KTM || stage_q == ST_WAIT);
  // R2
  stage_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    stage_q != 3'd7);
endmodule

// File: tb/motor_start_seq_tb.sv
module motor_start_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;
  localparam int NVEC       = 5;
  // ta, ho, band, dir, align_cyc, accel_cyc, rate_mhz, duty, steps_in_1600
  localparam int VEC [NVEC][9] = '{
    '{1, 1, 0, 1, 160,  337, 12500,  43, 30},
    '{0, 0, 2, 0, 160,  337, 12500,  60, 30},
    '{3, 2, 3, 1, 480,  773, 25000,  75, 60},
    '{2, 1, 5, 0, 320,  361, 12500, 100, 30},
    '{1, 3, 1, 1, 160, 1001, 37500,  50, 90}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ta_code, ho_code;
  logic [2:0]  vband;
  logic        dir, lock, fault;
  logic [2:0]  stage;
  logic [17:0] rate;
  logic [6:0]  duty;
  logic [2:0]  step;
  logic        tri_o;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_start_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ta_code_i(ta_code), .ho_code_i(ho_code),
    .vband_i(vband), .dir_i(dir), .lock_i(lock), .fault_i(fault),
    .stage_o(stage), .comm_rate_o(rate), .drive_duty_o(duty),
    .comm_step_o(step), .tristate_o(tri_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stage_len(input int s, output int n);
    n = 0;
    while (int'(stage) == s && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic watch_steps(input int ncyc, input int d, input string req, output int cnt);
    int prev;
    cnt = 0;
    prev = int'(step);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (int'(step) != prev) begin
        cnt++;
        chk(req, int'(step), d ? (prev + 1) % 6 : (prev + 5) % 6);
        prev = int'(step);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 stage", int'(stage), 0);
    chk("R1 tristate", int'(tri_o), 1);
    chk("R1 duty", int'(duty), 0);
    chk("R1 rate", int'(rate), 0);
    chk("R1 step", int'(step), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int n, st;
    rst_n = 1'b0; ta_code = 4'd1; ho_code = 4'd1; vband = 3'd0;
    dir = 1'b1; lock = 1'b0; fault = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      ta_code = 4'(VEC[v][0]); ho_code = 4'(VEC[v][1]);
      vband = 3'(VEC[v][2]); dir = VEC[v][3] != 0;
      do_reset();
      stage_len(0, n);
      chk("R1 R2 calibration after reset", n, 300 * TPM + 2);
      // R3 R4 R10
      chk("R2 order align", int'(stage), 1);
      chk("R3 align step", int'(step), 0);
      chk("R4 align duty", int'(duty), VEC[v][7]);
      chk("R10 align not floated", int'(tri_o), 0);
      stage_len(1, n);
      chk("R3 align length", n, VEC[v][4]);
      chk("R2 order rmeas", int'(stage), 2);
      stage_len(2, n);
      chk("R2 rmeas length", n, 10 * TPM);
      chk("R2 order ramp", int'(stage), 3);
      chk("R4 ramp duty", int'(duty), VEC[v][7]);
      stage_len(3, n);
      chk("R5 ramp length", n, VEC[v][5]);
      chk("R2 order ktm", int'(stage), 4);
      chk("R6 handoff rate", int'(rate), VEC[v][6]);
      stage_len(4, n);
      chk("R2 ktm length", n, 10 * TPM);
      chk("R2 order closed", int'(stage), 5);
      chk("R10 closed duty", int'(duty), 0);
      chk("R6 closed rate", int'(rate), VEC[v][6]);
      watch_steps(1600, VEC[v][3], "R8 step direction", n);
      chk("R7 step count", n, VEC[v][8]);
    end

    // R8: flip direction while running
    dir = 1'b0;
    watch_steps(800, 0, "R8 after flip", n);
    chk("R7 step count after flip", n, 45);

    // R9: lock in closed loop, flags during the wait are ignored
    lock = 1'b1;
    @(negedge clk);
    lock = 1'b0;
    chk("R9 lock to wait", int'(stage), 6);
    chk("R9 wait floated", int'(tri_o), 1);
    chk("R10 wait duty", int'(duty), 0);
    n = 0;
    while (int'(stage) == 6 && n < 100000) begin
      n++;
      fault = (n == 5000);
      @(negedge clk);
    end
    fault = 1'b0;
    chk("R9 wait length", n, 5000 * TPM);
    chk("R9 restart stage", int'(stage), 0);
    chk("R9 restart rate", int'(rate), 0);
    chk("R9 restart step", int'(step), 0);
    stage_len(0, n);
    chk("R2 calibration after wait", n, 300 * TPM);

    // R9: fault during alignment
    repeat (20) @(negedge clk);
    st = int'(stage);
    chk("R9 in align before fault", st, 1);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    chk("R9 fault to wait", int'(stage), 6);
    chk("R9 fault floated", int'(tri_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule